// File: doc/BRIEF.md
# ECC Error Capture Register Bank

This block records DRAM error events raised by a memory controller datapath. Correctable (single-bit) and uncorrectable (multi-bit) ECC events arrive as one-cycle pulses. Each pulse comes with the failing 33-bit physical address, the channel that held the data and the 8-bit syndrome. Three more event pulses report a refresh timeout, a locked access that targeted memory outside DRAM, and a thermal sensor trip. Each event sets a sticky status bit. Software clears a status bit by writing 1 to it.

Only one error context is held at a time, and an uncorrectable error takes precedence over a correctable one. The address is kept at a 128-byte grain. The first logged correctable error stays frozen until every status bit is clear, but an uncorrectable error still replaces it. Software sees this replacement when a second status read differs from the first. A command register selects which status bits drive a registered system-error output.

The registers are read through a combinational read port and written through a single-cycle write strobe. Word offsets: status 0, command 1, address pointer 2, extended address 3, syndrome 4.

Top module: `ecc_err_log`

## Requirements
- R1: The status register (offset 0) sets bit 0 on a correctable pulse, bit 1 on an uncorrectable pulse, bit 8 on a refresh timeout, bit 9 on a lock-to-non-DRAM pulse and bit 11 on a thermal pulse. Each bit stays set until it is cleared. All other bits read 0.
- R2: A write to offset 0 clears each status bit whose data bit is 1. A data bit of 0 leaves its status bit unchanged.
- R3: When an event pulse and a clear of the same status bit fall in the same cycle, the bit stays set.
- R4: The address pointer (offset 2) returns logged address bits 31:7 in bits 31:7 and the logged channel in bit 0. Bits 6:1 read 0.
- R5: The extended address register (offset 3) returns logged address bit 32 in bit 0. Bits 31:1 read 0.
- R6: The syndrome register (offset 4) returns the logged syndrome in bits 7:0. The upper bits read 0.
- R7: A correctable pulse captures address, channel and syndrome only when all status bits are 0. While any status bit is set, a correctable pulse leaves the captured data unchanged.
- R8: An uncorrectable pulse arriving while status bit 1 is clear captures its own address, channel and syndrome, replacing any correctable data. This also holds when a correctable pulse comes in the same cycle.
- R9: While status bit 1 is set, neither a correctable nor an uncorrectable pulse changes the captured data.
- R10: The command register (offset 1) is written at offset 1. It keeps only bits 0, 1, 8, 9 and 11. All other bits read 0.
- R11: `sys_err` is high exactly one cycle after a cycle in which status AND command is non-zero.
- R12: Synchronous reset clears status, command, captured data and `sys_err`. An unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_pulse | input | 1 | Correctable ECC error event |
| ue_pulse | input | 1 | Uncorrectable ECC error event |
| err_addr | input | 33 | Physical address of the ECC event |
| err_chan | input | 1 | Channel of the ECC event |
| err_syn | input | 8 | Syndrome of the ECC event |
| refresh_to_pulse | input | 1 | Refresh timeout event |
| lock_pulse | input | 1 | Locked access to non-DRAM memory event |
| thermal_pulse | input | 1 | Thermal sensor event |
| bus_addr | input | 3 | Register word offset for read and write |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sys_err | output | 1 | Registered system error |

## Verification
An event pulse presented before a clock edge shows in the status and capture registers right after that edge. Because the read port is combinational, it returns the new value in the same cycle. `sys_err` follows one edge later, since it is registered from status and command. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. It then compares both the read data (with the offset rotating through every register) and `sys_err` 1 ns after each rising edge, so every result is checked in the cycle it is due.

// File: rtl/ecc_log_pkg.sv
`timescale 1ns/1ps
package ecc_log_pkg;
    parameter int ERR_ADDR_W = 33;
    parameter int GRAIN_LSB  = 7;
    parameter int SYN_W      = 8;
    parameter int STAT_W     = 16;
    parameter int BUS_DW     = 32;
    parameter int BUS_AW     = 3;

    // status bit positions (decoded by software, so fixed)
    localparam int B_CE    = 0;
    localparam int B_UE    = 1;
    localparam int B_RFTO  = 8;
    localparam int B_LOCK  = 9;
    localparam int B_THERM = 11;

    localparam logic [STAT_W-1:0] ERR_MASK =
        STAT_W'((1 << B_CE) | (1 << B_UE) | (1 << B_RFTO) | (1 << B_LOCK) | (1 << B_THERM));

    localparam logic [BUS_AW-1:0] OFS_STAT = BUS_AW'(0);
    localparam logic [BUS_AW-1:0] OFS_CMD  = BUS_AW'(1);
    localparam logic [BUS_AW-1:0] OFS_APTR = BUS_AW'(2);
    localparam logic [BUS_AW-1:0] OFS_XADR = BUS_AW'(3);
    localparam logic [BUS_AW-1:0] OFS_SYND = BUS_AW'(4);

    typedef struct packed {
        logic thermal;
        logic lockf;
        logic refresh;
        logic ue;
        logic ce;
    } evt_t;

    typedef struct packed {
        logic [ERR_ADDR_W-1:GRAIN_LSB] addr;
        logic                          chan;
        logic [SYN_W-1:0]              syn;
    } cap_t;

    function automatic logic [STAT_W-1:0] evt_to_vec(evt_t e);
        logic [STAT_W-1:0] v;
        v          = '0;
        v[B_CE]    = e.ce;
        v[B_UE]    = e.ue;
        v[B_RFTO]  = e.refresh;
        v[B_LOCK]  = e.lockf;
        v[B_THERM] = e.thermal;
        return v;
    endfunction
endpackage

// File: rtl/ecc_log_status.sv
`timescale 1ns/1ps
module ecc_log_status
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] set_vec,
    input  logic [STAT_W-1:0] clr_vec,
    output logic [STAT_W-1:0] status
);
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (ERR_MASK[i]) begin : g_live
            logic b_q;
            always_ff @(posedge clk) begin
                if (rst)             b_q <= 1'b0;
                else if (set_vec[i]) b_q <= 1'b1;
                else if (clr_vec[i]) b_q <= 1'b0;
            end
            assign status[i] = b_q;
        end else begin : g_rsvd
            assign status[i] = 1'b0;
        end
    end
endmodule

// File: rtl/ecc_log_capture.sv
`timescale 1ns/1ps
module ecc_log_capture
    import ecc_log_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ce,
    input  logic                  ue,
    input  logic                  any_logged,
    input  logic                  ue_logged,
    input  logic [ERR_ADDR_W-1:0] addr,
    input  logic                  chan,
    input  logic [SYN_W-1:0]      syn,
    output cap_t                  cap
);
    logic take;
    // uncorrectable overrides unless one is already held; correctable only into an empty log
    assign take = (ue && !ue_logged) || (ce && !any_logged);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= '0;
        end else if (take) begin
            cap.addr <= addr[ERR_ADDR_W-1:GRAIN_LSB];
            cap.chan <= chan;
            cap.syn  <= syn;
        end
    end
endmodule

// File: rtl/ecc_log_cmd.sv
`timescale 1ns/1ps
module ecc_log_cmd
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wdata,
    input  logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] cmd,
    output logic              sys_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd     <= '0;
            sys_err <= 1'b0;
        end else begin
            if (wr_en) cmd <= wdata & ERR_MASK;
            sys_err <= |(status & cmd);
        end
    end
endmodule

// File: rtl/ecc_err_log.sv
`timescale 1ns/1ps
module ecc_err_log
    import ecc_log_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ce_pulse,
    input  logic                  ue_pulse,
    input  logic [ERR_ADDR_W-1:0] err_addr,
    input  logic                  err_chan,
    input  logic [SYN_W-1:0]      err_syn,
    input  logic                  refresh_to_pulse,
    input  logic                  lock_pulse,
    input  logic                  thermal_pulse,
    input  logic [BUS_AW-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [BUS_DW-1:0]     bus_wdata,
    output logic [BUS_DW-1:0]     bus_rdata,
    output logic                  sys_err
);
    evt_t              evt;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] cmd_q;
    cap_t              cap_q;
    logic              cmd_wr;

    assign evt     = '{thermal: thermal_pulse, lockf: lock_pulse, refresh: refresh_to_pulse,
                       ue: ue_pulse, ce: ce_pulse};
    assign set_vec = evt_to_vec(evt);
    assign clr_vec = (bus_we && bus_addr == OFS_STAT) ? (bus_wdata[STAT_W-1:0] & ERR_MASK) : '0;
    assign cmd_wr  = bus_we && bus_addr == OFS_CMD;

    ecc_log_status u_status (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .status  (status_q)
    );

    ecc_log_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .ce         (ce_pulse),
        .ue         (ue_pulse),
        .any_logged (|status_q),
        .ue_logged  (status_q[B_UE]),
        .addr       (err_addr),
        .chan       (err_chan),
        .syn        (err_syn),
        .cap        (cap_q)
    );

    ecc_log_cmd u_cmd (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cmd_wr),
        .wdata   (bus_wdata[STAT_W-1:0]),
        .status  (status_q),
        .cmd     (cmd_q),
        .sys_err (sys_err)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_STAT: bus_rdata[STAT_W-1:0] = status_q;
            OFS_CMD:  bus_rdata[STAT_W-1:0] = cmd_q;
            OFS_APTR: begin
                bus_rdata[BUS_DW-1:GRAIN_LSB] = cap_q.addr[BUS_DW-1:GRAIN_LSB];
                bus_rdata[0]                  = cap_q.chan;
            end
            OFS_XADR: bus_rdata[0] = cap_q.addr[ERR_ADDR_W-1];
            OFS_SYND: bus_rdata[SYN_W-1:0] = cap_q.syn;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ecc_err_log_chk.sv
`timescale 1ns/1ps
module ecc_err_log_chk
    import ecc_log_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        ce_pulse,
    input logic                        ue_pulse,
    input logic [SYN_W-1:0]            err_syn,
    input logic                        bus_we,
    input logic [BUS_AW-1:0]           bus_addr,
    input logic [BUS_DW-1:0]           bus_wdata,
    input logic [STAT_W-1:0]           st,
    input logic [STAT_W-1:0]           cmd,
    input logic [SYN_W-1:0]            cap_syn,
    input logic [ERR_ADDR_W-1:GRAIN_LSB] cap_addr,
    input logic                        sys_err
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (st & ~ERR_MASK) == '0); // R1
    AST_CMD_RSVD: assert property (@(posedge clk) disable iff (rst)
        (cmd & ~ERR_MASK) == '0); // R10
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_STAT && bus_wdata[B_CE] && !ce_pulse) |=> !st[B_CE]); // R2
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        ce_pulse |=> st[B_CE]); // R3
    AST_UE_SETS: assert property (@(posedge clk) disable iff (rst)
        ue_pulse |=> st[B_UE]); // R8
    AST_UE_TAKES: assert property (@(posedge clk) disable iff (rst)
        (ue_pulse && !st[B_UE]) |=> cap_syn == $past(err_syn)); // R8
    AST_CE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (ce_pulse && !ue_pulse && st != '0) |=> ($stable(cap_syn) && $stable(cap_addr))); // R7
    AST_UE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        st[B_UE] |=> ($stable(cap_syn) && $stable(cap_addr))); // R9
    AST_SYSERR_ON: assert property (@(posedge clk) disable iff (rst)
        ((st & cmd) != '0) |=> sys_err); // R11
    AST_SYSERR_OFF: assert property (@(posedge clk) disable iff (rst)
        ((st & cmd) == '0) |=> !sys_err); // R11
endmodule

bind ecc_err_log ecc_err_log_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_pulse  (ce_pulse),
    .ue_pulse  (ue_pulse),
    .err_syn   (err_syn),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .st        (status_q),
    .cmd       (cmd_q),
    .cap_syn   (cap_q.syn),
    .cap_addr  (cap_q.addr),
    .sys_err   (sys_err)
);

// File: tb/test_ecc_err_log.sv
`timescale 1ns/1ps
module test_ecc_err_log;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_pulse = 0, ue_pulse = 0, err_chan = 0;
    logic [32:0] err_addr = '0;
    logic [7:0]  err_syn = '0;
    logic        refresh_to_pulse = 0, lock_pulse = 0, thermal_pulse = 0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_err;

    int    n_chk = 0;
    int    n_bad = 0;
    string scen = "R12";
    int    rot = 0;
    bit    done = 0;

    // behavioural reference state
    logic [15:0] m_st, m_cmd;
    logic [32:0] m_addr;
    logic        m_chan, m_sys;
    logic [7:0]  m_syn;

    always #2.5 clk = ~clk;

    ecc_err_log i_ecc_err_log (
        .clk(clk), .rst(rst), .ce_pulse(ce_pulse), .ue_pulse(ue_pulse),
        .err_addr(err_addr), .err_chan(err_chan), .err_syn(err_syn),
        .refresh_to_pulse(refresh_to_pulse), .lock_pulse(lock_pulse),
        .thermal_pulse(thermal_pulse), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_err(sys_err)
    );

    always @(posedge clk) begin
        logic [15:0] ev;
        logic [15:0] clr;
        if (rst) begin
            m_st <= 0; m_cmd <= 0; m_addr <= 0; m_chan <= 0; m_syn <= 0; m_sys <= 0;
        end else begin
            ev = 16'h0;
            if (ce_pulse) ev = ev | 16'h0001;
            if (ue_pulse) ev = ev | 16'h0002;
            if (refresh_to_pulse) ev = ev | 16'h0100;
            if (lock_pulse) ev = ev | 16'h0200;
            if (thermal_pulse) ev = ev | 16'h0800;
            clr = (bus_we && bus_addr == 0) ? (bus_wdata[15:0] & 16'h0B03) : 16'h0;
            if ((ue_pulse && !m_st[1]) || (ce_pulse && m_st == 0)) begin
                m_addr <= {err_addr[32:7], 7'b0};
                m_chan <= err_chan;
                m_syn  <= err_syn;
            end
            if (bus_we && bus_addr == 1) m_cmd <= bus_wdata[15:0] & 16'h0B03;
            m_sys <= (m_st & m_cmd) != 0;
            m_st  <= (m_st & ~clr) | ev;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {16'h0, m_st};
            3'd1: return {16'h0, m_cmd};
            3'd2: return {m_addr[31:7], 6'b0, m_chan};
            3'd3: return {31'b0, m_addr[32]};
            3'd4: return {24'h0, m_syn};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string reg_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R1";
            3'd1: return "R10";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R12";
        endcase
    endfunction

    // compare every cycle, 1 ns after the rising edge
    always begin
        logic [31:0] e;
        @(posedge clk);
        #1;
        if (!done) begin
            e = exp_rd(bus_addr);
            n_chk++;
            if (bus_rdata !== e) begin
                n_bad++;
                $display("FAIL %s (%s) offset %0d: actual=%h expected=%h",
                         reg_tag(bus_addr), scen, bus_addr, bus_rdata, e);
            end
            n_chk++;
            if (sys_err !== m_sys) begin
                n_bad++;
                $display("FAIL R11 (%s) sys_err: actual=%b expected=%b", scen, sys_err, m_sys);
            end
        end
    end

    task automatic step(input bit ce, input bit ue, input bit rf, input bit lk, input bit th,
                        input logic [32:0] a, input bit ch, input logic [7:0] s,
                        input bit we, input logic [2:0] wa, input logic [31:0] wd);
        @(negedge clk);
        ce_pulse = ce; ue_pulse = ue; refresh_to_pulse = rf; lock_pulse = lk; thermal_pulse = th;
        err_addr = a; err_chan = ch; err_syn = s;
        bus_we = we; bus_wdata = wd;
        rot = (rot == 5) ? 0 : rot + 1;
        bus_addr = we ? wa : 3'(rot);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0,0,0,0,0, 33'h0, 0, 8'h0, 0, 3'd0, 32'h0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        step(0,0,0,0,0, 33'h0, 0, 8'h0, 1, a, d);
    endtask

    initial begin
        repeat (8) @(posedge clk);   // reset state compared every cycle: R12
        @(negedge clk); rst = 0;
        idle(6);

        scen = "R10"; wr(3'd1, 32'hFFFF_FFFF); idle(6);

        scen = "R7";  step(1,0,0,0,0, 33'h0_1234_5680, 1, 8'h5A, 0,0,0); idle(6);
        step(1,0,0,0,0, 33'h0_0BAD_0F00, 0, 8'h33, 0,0,0); idle(6);

        scen = "R8";  step(0,1,0,0,0, 33'h1_DEAD_BEFF, 0, 8'hC3, 0,0,0); idle(6);

        scen = "R9";  step(0,1,0,0,0, 33'h0_5555_5500, 1, 8'h11, 0,0,0);
        step(1,0,0,0,0, 33'h1_AAAA_AA80, 1, 8'h22, 0,0,0); idle(6);

        scen = "R2";  wr(3'd0, 32'h0000_0000); idle(6);
        wr(3'd0, 32'h0000_0001); idle(6);
        wr(3'd0, 32'hFFFF_FFFF); idle(6);

        scen = "R1";  step(0,0,1,0,0, 33'h0, 0, 0, 0,0,0); step(0,0,0,1,0, 33'h0, 0, 0, 0,0,0);
        step(0,0,0,0,1, 33'h0, 0, 0, 0,0,0); idle(6);
        scen = "R7";  step(1,0,0,0,0, 33'h0_7777_7700, 1, 8'h44, 0,0,0); idle(6);
        scen = "R8";  step(0,1,0,0,0, 33'h1_0000_0180, 1, 8'h99, 0,0,0); idle(6);

        scen = "R3";  step(1,0,1,0,0, 33'h0, 0, 0, 1, 3'd0, 32'h0000_0B03); idle(6);
        step(0,0,0,0,1, 33'h0, 0, 0, 1, 3'd0, 32'h0000_0800); idle(6);
        wr(3'd0, 32'h0000_0B03); idle(6);

        scen = "R8";  step(1,1,0,0,0, 33'h1_F0F0_F0F0, 1, 8'hE7, 0,0,0); idle(6);
        wr(3'd0, 32'h0000_0B03); idle(3);

        scen = "R11"; wr(3'd1, 32'h0000_0800); step(0,0,1,0,0, 33'h0,0,0,0,0,0); idle(4);
        step(0,0,0,0,1, 33'h0,0,0,0,0,0); idle(4);
        wr(3'd1, 32'h0); idle(4);
        wr(3'd1, 32'h0000_0001); idle(4);

        scen = "R12"; @(negedge clk); rst = 1; idle(4); @(negedge clk); rst = 0; idle(6);

        scen = "R7";
        wr(3'd1, 32'h0000_0B03);
        for (int k = 0; k < 2000; k++) begin
            int r;
            r = int'($urandom_range(0, 99));
            step(r < 12, r >= 12 && r < 18, r == 20, r == 21, r == 22,
                 {$urandom_range(0,1) == 1, 32'($urandom)}, $urandom_range(0,1) == 1,
                 8'($urandom), r >= 90, (r >= 96) ? 3'd1 : 3'd0, 32'($urandom));
        end
        idle(6);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        done = 1;
        n_chk++; n_bad++;
        $display("FAIL R12 watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule